// File: doc/BRIEF.md
# Single-Channel Multi-Mode DMA Engine

This block moves data between memory and an I/O device on behalf of the processor. Software loads a source address, a destination address, a unit count and a control word through a small register write port. When the device raises its request, the engine asks for the system bus and waits for the grant. It then moves one data unit, either in one bus cycle or in two.

In the one-cycle (flyby) mode, the engine drives only the memory address and raises the device acknowledge. The device drives or samples the data lines itself. In the two-cycle mode, the engine reads the source into an internal holding register and then writes that value to the destination. Separately, a bus-hold mode sets how the bus is given up between units. Single mode releases the bus and waits for a fresh device request. Step mode releases the bus and re-arbitrates at once if the request is still high. Block mode keeps the bus until the count runs out. When the last unit completes, a one-clock terminal-count pulse is raised and the channel disables itself.

Top module: `dma_chan`

## Requirements
- R1: `bus_req` is raised before any memory cycle. No memory cycle (`mem_req`) is issued unless `bus_gnt` is high, and `bus_req` stays high for as long as `mem_req` is high.
- R2: In two-cycle mode, each unit is a read of the source address whose data is captured internally, followed by a write of that same data to the destination address.
- R3: In flyby mode, each unit is exactly one memory cycle with `dev_ack` high. The memory address is the destination with `mem_we`=1 when control bit 2 is 1 (device to memory). It is the source with `mem_we`=0 when control bit 2 is 0 (memory to device). Only the memory-side address advances.
- R4: Hold mode 0 (single) drops `bus_req` after each unit. The next unit starts only after `dev_req` has gone low and then high again.
- R5: Hold mode 1 (step) drops `bus_req` for at least one cycle after each unit. It requests the bus again by itself while `dev_req` stays high.
- R6: Hold mode 2 (block) keeps `bus_req` high from the first unit to the last, and releases it only together with terminal count.
- R7: Each unit decrements the count. After the unit that ends at zero, `term_cnt` is high for exactly one clock with `bus_req` low. The enable bit is cleared, so later device requests raise no bus request.
- R8: Each address has its own step code: 0 = increment by DW/8 bytes, 1 = decrement by DW/8, 2 = fixed. The source code is in control bits 6:5 and the destination code in bits 8:7.
- R9: A channel that is enabled with a count of zero never requests the bus.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_we` hold their values into the next cycle.
- R11: Register select 0 writes the source address, 1 the destination address, 2 the count, and 3 the control word. In the control word, bit 0 is enable, bit 1 is 1 for flyby and 0 for two-cycle, bit 2 is the flyby direction, and bits 4:3 are the hold mode (3 behaves as single).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| dev_req | input | 1 | Device transfer request |
| dev_ack | output | 1 | Device acknowledge (flyby cycle) |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_req | output | 1 | Memory cycle valid |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ack | input | 1 | Memory cycle complete |
| term_cnt | output | 1 | Terminal-count pulse |

## Verification
The bench targets the points where the hold modes differ. Holding the device request high in single mode must not start a second unit, while the same stimulus in step mode must. A design that mixed the two would transfer too many or too few units. Block mode is counted for bus releases, since a design that re-arbitrated between units would show more than one release. A delayed grant must hold every memory cycle back, or a cycle would appear without ownership. Decrementing and fixed address steps are checked through the final memory contents and the logged addresses, so a wrong step shows as data landing in the wrong word. The bench also checks that a finished channel and a zero-count channel both ignore further requests, and that a design which failed to clear the enable bit would start again.

// File: rtl/dma_pkg.sv
package dma_pkg;

   typedef enum logic [1:0] {
      HOLD_SINGLE = 2'd0,
      HOLD_STEP   = 2'd1,
      HOLD_BLOCK  = 2'd2,
      HOLD_RSVD   = 2'd3
   } hold_e;

   typedef enum logic [1:0] {
      STEP_INC  = 2'd0,
      STEP_DEC  = 2'd1,
      STEP_FIX  = 2'd2,
      STEP_RSVD = 2'd3
   } step_e;

   // control word, MSB first
   typedef struct packed {
      step_e dst_step;
      step_e src_step;
      hold_e hold;
      logic  to_mem;
      logic  flyby;
      logic  en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   localparam logic [1:0] SEL_SRC  = 2'd0;
   localparam logic [1:0] SEL_DST  = 2'd1;
   localparam logic [1:0] SEL_CNT  = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ARB     = 3'd1,
      ST_RD      = 3'd2,
      ST_WR      = 3'd3,
      ST_FLY     = 3'd4,
      ST_HOLDOFF = 3'd5
   } state_e;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int AW         = 32,
   parameter int STEP_BYTES = 4
) (
   input  logic [AW-1:0]      cur,
   input  dma_pkg::step_e     mode,
   output logic [AW-1:0]      nxt
);
   import dma_pkg::*;

   localparam logic [AW-1:0] DELTA = AW'(STEP_BYTES);

   always_comb begin
      unique case (mode)
         STEP_INC: nxt = cur + DELTA;
         STEP_DEC: nxt = cur - DELTA;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/dma_regs.sv
module dma_regs #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [AW-1:0]     cfg_wdata,
   input  logic              adv_src,
   input  logic              adv_dst,
   input  logic              dec_cnt,
   input  logic              clr_en,
   output logic [AW-1:0]     src_addr,
   output logic [AW-1:0]     dst_addr,
   output dma_pkg::ctrl_t    ctrl,
   output logic              cnt_last,
   output logic              cnt_zero
);
   import dma_pkg::*;

   localparam int STEP_BYTES = DW / 8;
   localparam int NADDR      = 2;

   logic [AW-1:0] addr_q [NADDR];
   logic [CW-1:0] cnt_q;
   ctrl_t         ctrl_q;

   logic [NADDR-1:0] adv;
   step_e            smode [NADDR];
   logic [1:0]       asel  [NADDR];

   assign adv[0]   = adv_src;
   assign adv[1]   = adv_dst;
   assign smode[0] = ctrl_q.src_step;
   assign smode[1] = ctrl_q.dst_step;
   assign asel[0]  = SEL_SRC;
   assign asel[1]  = SEL_DST;

   for (genvar i = 0; i < NADDR; i++) begin : g_addr
      logic [AW-1:0] nxt;

      dma_addr_step #(.AW(AW), .STEP_BYTES(STEP_BYTES)) u_step (
         .cur  (addr_q[i]),
         .mode (smode[i]),
         .nxt  (nxt)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           addr_q[i] <= '0;
         else if (adv[i])                      addr_q[i] <= nxt;
         else if (cfg_we && cfg_sel == asel[i]) addr_q[i] <= cfg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt_q <= '0;
      else if (dec_cnt)                      cnt_q <= cnt_q - 1'b1;
      else if (cfg_we && cfg_sel == SEL_CNT) cnt_q <= cfg_wdata[CW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctrl_q <= ctrl_t'('0);
      else if (clr_en)                        ctrl_q.en <= 1'b0;
      else if (cfg_we && cfg_sel == SEL_CTRL) ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
   end

   assign src_addr = addr_q[0];
   assign dst_addr = addr_q[1];
   assign ctrl     = ctrl_q;
   assign cnt_last = (cnt_q == CW'(1));
   assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              flyby,
   input  logic              to_mem,
   input  dma_pkg::hold_e    hold,
   input  logic              cnt_last,
   input  logic              cnt_zero,
   input  logic [AW-1:0]     src_addr,
   input  logic [AW-1:0]     dst_addr,
   input  logic              dev_req,
   input  logic              bus_gnt,
   input  logic              mem_ack,
   input  logic [DW-1:0]     mem_rdata,
   output logic              dev_ack,
   output logic              bus_req,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic              term_cnt,
   output logic              adv_src,
   output logic              adv_dst,
   output logic              dec_cnt,
   output logic              clr_en
);
   import dma_pkg::*;

   state_e        st, st_nxt;
   logic [DW-1:0] hold_q;
   logic          tc_q;
   logic          unit_done;
   state_e        xfer_st;

   assign xfer_st   = flyby ? ST_FLY : ST_RD;
   assign unit_done = mem_ack && (st == ST_WR || st == ST_FLY);

   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_IDLE:    if (en && !cnt_zero && dev_req) st_nxt = ST_ARB;
         ST_ARB:     if (bus_gnt) st_nxt = xfer_st;
         ST_RD:      if (mem_ack) st_nxt = ST_WR;
         ST_WR, ST_FLY: begin
            if (mem_ack) begin
               if (cnt_last) st_nxt = ST_IDLE;
               else begin
                  unique case (hold)
                     HOLD_BLOCK: st_nxt = xfer_st;
                     HOLD_STEP:  st_nxt = ST_IDLE;
                     default:    st_nxt = ST_HOLDOFF;
                  endcase
               end
            end
         end
         ST_HOLDOFF: if (!dev_req) st_nxt = ST_IDLE;
         default:    st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         hold_q <= '0;
         tc_q   <= 1'b0;
      end else begin
         st   <= st_nxt;
         tc_q <= unit_done && cnt_last;
         if (st == ST_RD && mem_ack) hold_q <= mem_rdata;
      end
   end

   always_comb begin
      mem_addr = src_addr;
      mem_we   = 1'b0;
      unique case (st)
         ST_WR:  begin mem_addr = dst_addr; mem_we = 1'b1; end
         ST_FLY: begin mem_addr = to_mem ? dst_addr : src_addr; mem_we = to_mem; end
         default: ;
      endcase
   end

   assign mem_req   = (st == ST_RD) || (st == ST_WR) || (st == ST_FLY);
   assign bus_req   = mem_req || (st == ST_ARB);
   assign dev_ack   = (st == ST_FLY);
   assign mem_wdata = hold_q;
   assign term_cnt  = tc_q;
   assign adv_src   = unit_done && (!flyby || !to_mem);
   assign adv_dst   = unit_done && (!flyby || to_mem);
   assign dec_cnt   = unit_done;
   assign clr_en    = unit_done && cnt_last;

endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          dev_req,
   output logic          dev_ack,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack,
   output logic          term_cnt
);
   import dma_pkg::*;

   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("dma_chan: DW must be a positive multiple of 8");
   end
   if (CW < 1 || CW > AW) begin : g_bad_cw
      $error("dma_chan: CW must lie in 1..AW");
   end
   if (CTRL_W > AW) begin : g_bad_aw
      $error("dma_chan: AW too narrow for the control word");
   end

   logic [AW-1:0] src_addr, dst_addr;
   ctrl_t         ctrl_q;
   logic          cnt_last, cnt_zero;
   logic          adv_src, adv_dst, dec_cnt, clr_en;

   dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .adv_src   (adv_src),
      .adv_dst   (adv_dst),
      .dec_cnt   (dec_cnt),
      .clr_en    (clr_en),
      .src_addr  (src_addr),
      .dst_addr  (dst_addr),
      .ctrl      (ctrl_q),
      .cnt_last  (cnt_last),
      .cnt_zero  (cnt_zero)
   );

   dma_fsm #(.AW(AW), .DW(DW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctrl_q.en),
      .flyby     (ctrl_q.flyby),
      .to_mem    (ctrl_q.to_mem),
      .hold      (ctrl_q.hold),
      .cnt_last  (cnt_last),
      .cnt_zero  (cnt_zero),
      .src_addr  (src_addr),
      .dst_addr  (dst_addr),
      .dev_req   (dev_req),
      .bus_gnt   (bus_gnt),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .dev_ack   (dev_ack),
      .bus_req   (bus_req),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .term_cnt  (term_cnt),
      .adv_src   (adv_src),
      .adv_dst   (adv_dst),
      .dec_cnt   (dec_cnt),
      .clr_en    (clr_en)
   );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic          mem_req,
   input logic          mem_ack,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          dev_ack,
   input logic          term_cnt,
   input logic          blk_mode
);

   // R1
   cycle_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> bus_gnt);

   // R1
   cycle_holds_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> bus_req);

   // R3
   ack_within_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> mem_req);

   // R6
   block_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_req) && blk_mode) |-> term_cnt);

   // R7
   tc_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_cnt |=> !term_cnt);

   // R7
   tc_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_cnt |-> !bus_req);

   // R10
   cycle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind dma_chan dma_chan_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_gnt  (bus_gnt),
   .mem_req  (mem_req),
   .mem_ack  (mem_ack),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .dev_ack  (dev_ack),
   .term_cnt (term_cnt),
   .blk_mode (ctrl_q.hold == dma_pkg::HOLD_BLOCK)
);

// File: tb/dma_chan_bench.sv
module dma_chan_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          dev_req = 1'b0;
   logic          dev_ack, bus_req, mem_req, mem_we, term_cnt;
   logic          bus_gnt = 1'b0;
   logic          gnt_en = 1'b1;
   logic          ack_r = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic [31:0]   mem [64];

   int checks = 0, errors = 0;
   int n_rd, n_wr, n_fly, n_rel, n_tc, n_tcwide, n_nogrant, n_hq, n_unstable;
   logic [31:0] rd_a [16];
   logic [31:0] wr_a [16];
   logic [31:0] fly_a [16];
   logic        fly_w [16];
   logic        bus_req_d = 1'b0, tc_d = 1'b0, pend_d = 1'b0;
   logic [31:0] addr_d = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chan #(.AW(AW), .DW(DW), .CW(16)) u_dma_chan (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(ack_r), .term_cnt(term_cnt)
   );

   assign mem_rdata = mem[mem_addr[7:2]];

   // bus arbiter and one-wait-state memory
   always @(posedge clk) begin
      bus_gnt <= bus_req && gnt_en;
      ack_r   <= mem_req && !ack_r;
   end

   // monitor
   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_req && ack_r) begin
            if (dev_ack) begin
               fly_a[n_fly & 15] = mem_addr; fly_w[n_fly & 15] = mem_we; n_fly++;
            end else if (mem_we) begin
               mem[mem_addr[7:2]] = mem_wdata; wr_a[n_wr & 15] = mem_addr; n_wr++;
            end else begin
               rd_a[n_rd & 15] = mem_addr; n_rd++;
            end
         end
         if (bus_req_d && !bus_req) n_rel++;
         if (term_cnt) n_tc++;
         if (term_cnt && tc_d) n_tcwide++;
         if (mem_req && !bus_gnt) n_nogrant++;
         if (bus_req) n_hq++;
         if (pend_d && (!mem_req || mem_addr != addr_d)) n_unstable++;
      end
      bus_req_d = bus_req;
      tc_d      = term_cnt;
      pend_d    = mem_req && !ack_r;
      addr_d    = mem_addr;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_stats();
      n_rd = 0; n_wr = 0; n_fly = 0; n_rel = 0; n_tc = 0; n_tcwide = 0;
      n_nogrant = 0; n_hq = 0; n_unstable = 0;
      for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + i;
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input logic [31:0] src, input logic [31:0] dst,
                        input logic [31:0] cnt, input logic [31:0] ctl);
      wr_reg(2'd0, src); wr_reg(2'd1, dst); wr_reg(2'd2, cnt); wr_reg(2'd3, ctl);
   endtask

   task automatic wait_tc(input string req);
      int t = 0;
      while (n_tc == 0 && t < 400) begin @(negedge clk); t++; end
      chk({req, " terminal count seen"}, n_tc, 1);
      chk({req, " tc width"}, n_tcwide, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 reset bus_req", bus_req, 0);
      chk("R1 reset mem_req", mem_req, 0);
      chk("R7 reset term_cnt", term_cnt, 0);
      chk("R3 reset dev_ack", dev_ack, 0);
   endtask

   // two-cycle, block, both incrementing (R2 R6 R8 R10 R11)
   task automatic t_block_copy();
      clear_stats();
      setup(32'h00, 32'h80, 4, 32'h011);
      dev_req = 1'b1;
      wait_tc("R6");
      dev_req = 1'b0;
      chk("R2 reads", n_rd, 4);
      chk("R2 writes", n_wr, 4);
      for (int i = 0; i < 4; i++) chk("R2 R8 R11 copied word", mem[32+i], 32'hA000_0000 + i);
      chk("R6 bus releases", n_rel, 1);
      chk("R10 held cycles", n_unstable, 0);
   endtask

   // two-cycle, step, source decrement, destination fixed (R5 R8)
   task automatic t_step_dec();
      clear_stats();
      setup(32'h0C, 32'hC0, 3, 32'h129);
      dev_req = 1'b1;
      wait_tc("R5");
      dev_req = 1'b0;
      chk("R5 units", n_wr, 3);
      chk("R5 bus releases", n_rel, 3);
      chk("R8 first read addr", rd_a[0], 32'h0C);
      chk("R8 last read addr", rd_a[2], 32'h04);
      chk("R8 fixed dest addr", wr_a[2], 32'hC0);
      chk("R2 last data", mem[48], 32'hA000_0001);
   endtask

   // flyby device-to-memory, single (R3 R4)
   task automatic t_single_fly();
      clear_stats();
      setup(32'h100, 32'h40, 3, 32'h007);
      for (int k = 0; k < 3; k++) begin
         int t = 0;
         dev_req = 1'b1;
         while (n_fly < k + 1 && t < 100) begin @(negedge clk); t++; end
         repeat (12) @(negedge clk);
         chk("R4 one unit per request", n_fly, k + 1);
         chk("R4 bus released", bus_req, 0);
         dev_req = 1'b0;
         repeat (2) @(negedge clk);
      end
      chk("R7 tc after last", n_tc, 1);
      chk("R3 no two-cycle traffic", n_rd + n_wr, 0);
      chk("R3 fly addr 0", fly_a[0], 32'h40);
      chk("R3 fly addr 2", fly_a[2], 32'h48);
      chk("R3 fly write", fly_w[1], 1);
      chk("R4 bus releases", n_rel, 3);
   endtask

   // flyby memory-to-device, block, source fixed (R3 R6)
   task automatic t_block_fly_rd();
      clear_stats();
      setup(32'h20, 32'h60, 2, 32'h053);
      dev_req = 1'b1;
      wait_tc("R3");
      dev_req = 1'b0;
      chk("R3 fly units", n_fly, 2);
      chk("R3 fly read dir", fly_w[0] | fly_w[1], 0);
      chk("R3 fly src fixed", fly_a[1], 32'h20);
      chk("R6 bus releases", n_rel, 1);
   endtask

   // delayed grant, then enable cleared (R1 R7)
   task automatic t_grant_delay();
      clear_stats();
      gnt_en = 1'b0;
      setup(32'h00, 32'h90, 1, 32'h011);
      dev_req = 1'b1;
      repeat (10) @(negedge clk);
      chk("R1 request pending", bus_req, 1);
      chk("R1 no cycle before grant", n_rd + n_wr, 0);
      gnt_en = 1'b1;
      wait_tc("R1");
      chk("R1 data moved", mem[36], 32'hA000_0000);
      chk("R1 no cycle without grant", n_nogrant, 0);
      n_hq = 0;
      repeat (20) @(negedge clk);
      chk("R7 finished channel ignores request", n_hq, 0);
      dev_req = 1'b0;
   endtask

   // zero count (R9)
   task automatic t_zero_count();
      clear_stats();
      setup(32'h00, 32'hA0, 0, 32'h011);
      dev_req = 1'b1;
      repeat (20) @(negedge clk);
      chk("R9 no bus request", n_hq, 0);
      chk("R9 no terminal count", n_tc, 0);
      dev_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      clear_stats();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_block_copy();
      t_step_dec();
      t_single_fly();
      t_block_fly_rd();
      t_grant_delay();
      t_zero_count();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule